// File: doc/BRIEF.md
# Encoded SPI clock divider

This block derives a serial flash clock and a pair of edge strobes from the system clock. Each chip select owns a 32-bit control word. The divisor is not held in binary. A 4-bit permuted code chooses a fine divisor from 1 to 16. Depending on the build variant, a prescale bit can multiply that divisor by four, or a 4-bit coarse field can add multiples of 16 to it. The word of the currently selected chip select sets the active divisor. A shift engine that sits next to the block consumes the rising and falling strobes.

While `run` is low, the serial clock rests low and no strobes are produced. When `run` goes high, the waveform begins at the start of a period. The serial clock is a registered output of a counter in the system clock domain, so no clock is gated. Three variants are available through the `VARIANT` parameter: fine code only, fine code with ×4 prescale, and fine code with a coarse base. A chip-select value beyond the last configured chip select decodes as the default word 0x0400.

Top module: `spiclk_gen`

## Requirements
- R1: The fine code c sits in bits [11:8] of the selected word. Codes 8 to 15 give the odd divisor 2·(15−c)+1, and codes 0 to 7 give the even divisor 2·(8−c). So code 15 is divide-by-1 and code 0 is divide-by-16.
- R2: In the prescale variant, bit 13 set multiplies the fine divisor by 4. In the other two variants, bit 13 has no effect.
- R3: In the coarse variant, bits [27:24] hold j, and the divisor is the fine divisor plus 16·j, up to 256. In the other two variants, bits [27:24] have no effect.
- R4: In the coarse variant, j = 0 combined with fine code 15 produces divide-by-2 instead of divide-by-1.
- R5: The word 0x0400 (fine code 4, j = 0, bit 13 clear) produces divide-by-8 in every variant.
- R6: The word for chip select k occupies bits [32k+31:32k] of `cfg_words`. The word selected by `cs_sel` alone sets the divisor.
- R7: At every clock edge where `run` is sampled low, `sclk` is driven low and both strobes are driven low. This covers the first edge after `run` drops.
- R8: At the first edge where `run` is sampled high after being low, `rise_stb` is asserted, and `sclk` goes high whenever the divisor is 2 or more.
- R9: With divisor N ≥ 2, the output repeats every N cycles. `sclk` stays high for floor(N/2) cycles and low for the remaining cycles. `rise_stb` marks the first high cycle and `fall_stb` marks the first low cycle.
- R10: With divisor 1, `sclk` stays low and both `rise_stb` and `fall_stb` are asserted in every running cycle.
- R11: While `rst` is high, `sclk`, `rise_stb` and `fall_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_words | input | 32·NUM_CS | One divider control word per chip select |
| cs_sel | input | CS_W | Chip select whose word is active |
| run | input | 1 | Enables clock generation |
| sclk | output | 1 | Serial clock level |
| rise_stb | output | 1 | Asserted in the cycle in which sclk rises |
| fall_stb | output | 1 | Asserted in the cycle in which sclk falls |

## Verification
The bench drives all three variants with the same stimulus. It covers every fine code, the divide-by-1 word that the coarse variant must raise to divide-by-2, the largest divisor of 256, odd divisors, and words for each chip select that differ from one another. Each failure mode shows up as a visible symptom:
- A decoder with the permutation wrong produces the wrong period.
- A design that honours divide-by-1 in the coarse variant toggles at half the expected period.
- A design that leaks the prescale bit or the coarse field into the wrong variant stretches the period.
- Getting the odd-divisor split wrong swaps the lengths of the high and low phases.

Starting and stopping are checked on the first edge after `run` changes. A design that resumes from a stale count, or leaves `sclk` high, fails there.

// File: rtl/spiclk_pkg.sv
`timescale 1ns/1ps
package spiclk_pkg;

    typedef enum logic [1:0] {
        DIV_BASIC    = 2'd0,
        DIV_PRESCALE = 2'd1,
        DIV_COARSE   = 2'd2
    } div_variant_e;

    localparam int CFG_W        = 32;
    localparam int CODE_W       = 4;
    localparam int FINE_LSB     = 8;
    localparam int PRESCALE_BIT = 13;
    localparam int COARSE_LSB   = 24;
    localparam int FINE_MAX     = 1 << CODE_W;
    localparam int MAX_DIV      = FINE_MAX * FINE_MAX;
    localparam int DIV_W        = $clog2(MAX_DIV + 1);

    localparam logic [CFG_W-1:0] CFG_DEFAULT = 32'h0000_0400;

    typedef struct packed {
        logic [CODE_W-1:0] coarse;
        logic              prescale;
        logic [CODE_W-1:0] fine;
    } div_fields_t;

    // Permuted code to divisor: divisor-1 = {~c[2:0], ~c[3]}
    function automatic logic [CODE_W:0] fine_divisor(input logic [CODE_W-1:0] code);
        logic [CODE_W:0] m1;
        m1 = {1'b0, ~code[2:0], ~code[3]};
        return m1 + 1'b1;
    endfunction

    function automatic div_fields_t unpack_word(input logic [CFG_W-1:0] w);
        div_fields_t f;
        f.fine     = w[FINE_LSB +: CODE_W];
        f.prescale = w[PRESCALE_BIT];
        f.coarse   = w[COARSE_LSB +: CODE_W];
        return f;
    endfunction

endpackage

// File: rtl/spiclk_cs_mux.sv
`timescale 1ns/1ps
module spiclk_cs_mux
    import spiclk_pkg::*;
#(
    parameter int NUM_CS = 5,
    parameter int CS_W   = 3
) (
    input  logic [NUM_CS*CFG_W-1:0] cfg_words,
    input  logic [CS_W-1:0]         cs_sel,
    output div_fields_t             fields
);

    logic [CFG_W-1:0] word_arr [NUM_CS];
    logic [CFG_W-1:0] sel_word;
    logic             unused_bits;

    generate
        for (genvar i = 0; i < NUM_CS; i++) begin : g_split
            assign word_arr[i] = cfg_words[i*CFG_W +: CFG_W];
        end
    endgenerate

    always_comb begin
        sel_word = CFG_DEFAULT;
        for (int i = 0; i < NUM_CS; i++) begin
            if (cs_sel == CS_W'(i)) sel_word = word_arr[i];
        end
    end

    assign fields      = unpack_word(sel_word);
    assign unused_bits = ^{sel_word[31:28], sel_word[23:14], sel_word[12], sel_word[7:0]};

endmodule

// File: rtl/spiclk_div_decode.sv
`timescale 1ns/1ps
module spiclk_div_decode
    import spiclk_pkg::*;
#(
    parameter div_variant_e VARIANT = DIV_COARSE
) (
    input  div_fields_t       fields,
    output logic [DIV_W-1:0]  div_n
);

    logic [DIV_W-1:0] fine_n;
    logic [DIV_W-1:0] pre_n;
    logic [DIV_W-1:0] crs_n;

    always_comb begin
        fine_n = DIV_W'(fine_divisor(fields.fine));
        pre_n  = fields.prescale ? (fine_n << 2) : fine_n;
        crs_n  = fine_n + DIV_W'({fields.coarse, {CODE_W{1'b0}}});
        if (fields.coarse == '0 && fine_n == DIV_W'(1)) crs_n = DIV_W'(2);
        case (VARIANT)
            DIV_PRESCALE: div_n = pre_n;
            DIV_COARSE:   div_n = crs_n;
            default:      div_n = fine_n;
        endcase
    end

endmodule

// File: rtl/spiclk_phase_gen.sv
`timescale 1ns/1ps
module spiclk_phase_gen
    import spiclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             sclk,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] pos;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] last;

    always_comb begin
        pos  = (cnt < div_n) ? cnt : '0;
        half = div_n >> 1;
        last = div_n - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt      <= '0;
            sclk     <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            cnt      <= (pos == last) ? '0 : pos + 1'b1;
            sclk     <= (pos < half);
            rise_stb <= (pos == '0);
            fall_stb <= (pos == half);
        end
    end

endmodule

// File: rtl/spiclk_gen.sv
`timescale 1ns/1ps
module spiclk_gen
    import spiclk_pkg::*;
#(
    parameter int           NUM_CS  = 5,
    parameter div_variant_e VARIANT = DIV_COARSE,
    localparam int          CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CS*CFG_W-1:0] cfg_words,
    input  logic [CS_W-1:0]         cs_sel,
    input  logic                    run,
    output logic                    sclk,
    output logic                    rise_stb,
    output logic                    fall_stb
);

    div_fields_t      fields;
    logic [DIV_W-1:0] div_n;

    spiclk_cs_mux #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_mux (
        .cfg_words (cfg_words),
        .cs_sel    (cs_sel),
        .fields    (fields)
    );

    spiclk_div_decode #(.VARIANT(VARIANT)) u_dec (
        .fields (fields),
        .div_n  (div_n)
    );

    spiclk_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .div_n    (div_n),
        .sclk     (sclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

endmodule

// File: rtl/spiclk_gen_chk.sv
`timescale 1ns/1ps
module spiclk_gen_chk
    import spiclk_pkg::*;
#(
    parameter div_variant_e VARIANT = DIV_COARSE
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             sclk,
    input logic             rise_stb,
    input logic             fall_stb,
    input logic [DIV_W-1:0] div_n
);

    logic [DIV_W-1:0] hi_cnt;
    logic [DIV_W-1:0] prev_div;
    logic             moved;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt   <= '0;
            prev_div <= '0;
            moved    <= 1'b0;
        end else begin
            hi_cnt   <= sclk ? hi_cnt + 1'b1 : '0;
            prev_div <= div_n;
            if (!sclk && !run) moved <= 1'b0;
            else if (div_n != prev_div) moved <= 1'b1;
            else if (!sclk && rise_stb) moved <= 1'b0;
        end
    end

    // R7
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!sclk && !rise_stb && !fall_stb));

    // R7
    strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (rise_stb || fall_stb) |-> $past(run));

    // R8
    clean_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |=> rise_stb);

    // R9
    rise_mark_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> (rise_stb && !fall_stb));

    // R9
    fall_mark_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(sclk) && $past(run)) |-> fall_stb);

    // R9
    high_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(sclk) && $past(run) && !moved && !$past(moved)) |->
            (hi_cnt == ($past(div_n) >> 1)));

    // R10
    div_one_chk: assert property (@(posedge clk) disable iff (rst)
        (run && div_n == DIV_W'(1) && $past(div_n) == DIV_W'(1)) |=>
            (rise_stb && fall_stb && !sclk));

    generate
        if (VARIANT == DIV_COARSE) begin : g_coarse
            // R4
            coarse_min_chk: assert property (@(posedge clk) disable iff (rst)
                div_n >= DIV_W'(2));
        end
    endgenerate

endmodule

bind spiclk_gen spiclk_gen_chk #(.VARIANT(VARIANT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .sclk     (sclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .div_n    (div_n)
);

// File: tb/test_spiclk_gen.sv
`timescale 1ns/1ps
module test_spiclk_gen;
    import spiclk_pkg::*;

    localparam int NCS = 5;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NCS*32-1:0]  cfg = '0;
    logic [2:0]         cs  = '0;
    logic               run = 1'b0;
    logic [2:0]         got [3];
    logic               s_c, r_c, f_c, s_p, r_p, f_p, s_b, r_b, f_b;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    spiclk_gen #(.NUM_CS(NCS), .VARIANT(DIV_COARSE)) i_spiclk_gen (
        .clk(clk), .rst(rst), .cfg_words(cfg), .cs_sel(cs), .run(run),
        .sclk(s_c), .rise_stb(r_c), .fall_stb(f_c));
    spiclk_gen #(.NUM_CS(NCS), .VARIANT(DIV_PRESCALE)) i_spiclk_gen_pre (
        .clk(clk), .rst(rst), .cfg_words(cfg), .cs_sel(cs), .run(run),
        .sclk(s_p), .rise_stb(r_p), .fall_stb(f_p));
    spiclk_gen #(.NUM_CS(NCS), .VARIANT(DIV_BASIC)) i_spiclk_gen_basic (
        .clk(clk), .rst(rst), .cfg_words(cfg), .cs_sel(cs), .run(run),
        .sclk(s_b), .rise_stb(r_b), .fall_stb(f_b));

    assign got[0] = {s_c, r_c, f_c};
    assign got[1] = {s_p, r_p, f_p};
    assign got[2] = {s_b, r_b, f_b};

    function automatic int fine_of(input logic [3:0] c);
        case (c)
            4'd0: return 16;  4'd1: return 14;  4'd2: return 12;  4'd3: return 10;
            4'd4: return 8;   4'd5: return 6;   4'd6: return 4;   4'd7: return 2;
            4'd8: return 15;  4'd9: return 13;  4'd10: return 11; 4'd11: return 9;
            4'd12: return 7;  4'd13: return 5;  4'd14: return 3;  default: return 1;
        endcase
    endfunction

    // idx 0 coarse, 1 prescale, 2 basic
    function automatic int exp_div(input int idx, input logic [31:0] w);
        int f;
        int j;
        f = fine_of(w[11:8]);
        j = int'(w[27:24]);
        if (idx == 0) begin
            if (j == 0 && f == 1) return 2;
            return f + 16 * j;
        end
        if (idx == 1) return w[13] ? 4 * f : f;
        return f;
    endfunction

    function automatic logic [2:0] exp_wave(input int n, input int k);
        int p;
        int h;
        p = k % n;
        h = n / 2;
        return {(p < h), (p == 0), (p == h)};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_case(input logic [NCS*32-1:0] w, input int sel, input string tag);
        int n [3];
        int errs [3];
        logic [2:0] fa [3];
        logic [2:0] fe [3];
        int len;
        logic [31:0] word;
        @(negedge clk);
        run = 1'b0;
        cfg = w;
        cs  = 3'(sel);
        repeat (2) @(negedge clk);
        chk({got[0], got[1], got[2]} == 9'b0, "R7 idle before start", int'({got[0], got[1], got[2]}), 0);
        word = w[sel*32 +: 32];
        len = 0;
        for (int i = 0; i < 3; i++) begin
            n[i] = exp_div(i, word);
            errs[i] = 0;
            fa[i] = '0;
            fe[i] = '0;
            if (2 * n[i] + 3 > len) len = 2 * n[i] + 3;
        end
        run = 1'b1;
        for (int k = 0; k < len; k++) begin
            @(posedge clk);
            #1;
            for (int i = 0; i < 3; i++) begin
                if (got[i] !== exp_wave(n[i], k)) begin
                    if (errs[i] == 0) begin
                        fa[i] = got[i];
                        fe[i] = exp_wave(n[i], k);
                    end
                    errs[i]++;
                end
            end
        end
        for (int i = 0; i < 3; i++) begin
            chk(errs[i] == 0, $sformatf("%s variant%0d div%0d wave{sclk,rise,fall}", tag, i, n[i]),
                int'(fa[i]), int'(fe[i]));
        end
        @(negedge clk);
        run = 1'b0;
        @(posedge clk);
        #1;
        chk({got[0], got[1], got[2]} == 9'b0, "R7 stop low on first edge", int'({got[0], got[1], got[2]}), 0);
    endtask

    function automatic logic [NCS*32-1:0] all_cs(input logic [31:0] w);
        logic [NCS*32-1:0] v;
        for (int i = 0; i < NCS; i++) v[i*32 +: 32] = w;
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not end, actual=%0d cycles expected fewer", 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [NCS*32-1:0] v;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        run = 1'b1;
        @(posedge clk);
        #1;
        // R11: outputs held low in reset even with run high
        chk({got[0], got[1], got[2]} == 9'b0, "R11 reset outputs", int'({got[0], got[1], got[2]}), 0);
        @(negedge clk);
        run = 1'b0;
        rst = 1'b0;

        // R5 default word
        run_case(all_cs(32'h0000_0400), 0, "R5 R9");
        // R10 divide-by-1 (prescale/basic) and R4 coarse raised to 2
        run_case(all_cs(32'h0000_0F00), 1, "R4 R10");
        // R2 prescale bit: x4 only in prescale variant
        run_case(all_cs(32'h0000_2F00), 2, "R2");
        // R3 largest coarse divisor, prescale too
        run_case(all_cs(32'h0F00_2000), 3, "R3 R2");
        // R3 odd divisor with coarse field, R9 odd split
        run_case(all_cs(32'h0100_0800), 4, "R3 R9");
        // R1 every fine code
        for (int c = 0; c < 16; c++) begin
            run_case(all_cs({20'h0, 4'(c), 8'h00}), 2, "R1 R8 R9");
        end
        // R6 distinct word per chip select
        v = '0;
        v[0*32 +: 32] = 32'h0000_0700;
        v[1*32 +: 32] = 32'h0000_0E00;
        v[2*32 +: 32] = 32'h0200_0300;
        v[3*32 +: 32] = 32'h0000_2900;
        v[4*32 +: 32] = 32'h0000_0C00;
        for (int s = 0; s < NCS; s++) run_case(v, s, "R6");
        // random mix
        for (int t = 0; t < 30; t++) begin
            for (int i = 0; i < NCS; i++) v[i*32 +: 32] = $urandom;
            run_case(v, int'($urandom_range(0, NCS - 1)), "R1 R2 R3 R6 R9");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule